// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines and presents one interrupt line to a processor. It keeps three registers: pending requests, requests in service and a mask. Input 0 always has the highest priority and the highest index the lowest. A single configuration pin selects the trigger mode for all inputs. In edge mode a line must go from low to high to post a request. In level mode a high line is a request for as long as it stays high.

The processor answers an interrupt with two acknowledge pulses. At the end of the first pulse the controller chooses the winning input, sets its in-service bit and records its number. At the end of the second pulse it presents that number as a vector code. If the request has gone away before the first pulse ends, the code is the lowest-priority input number and no in-service bit is set. A processor that does not take the interrupt line can poll instead: it writes a poll command and then reads. That read returns the winning input and acknowledges it.

The register port has one address bit. A write to address 0 carries a command byte. A write to address 1 loads the mask. Reads are registered and appear on `rdata` in the cycle after `rd_en`, where they stay until the next read.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With `level_mode`=0, a request bit is set only after its input has been seen low and then high. An input that stays high after it has been acknowledged does not post a request again.
- R2: With `level_mode`=1, a high input is a request. An input still high when its in-service bit is cleared by end-of-interrupt raises `irq` again.
- R3: If no unmasked request is pending when the first acknowledge pulse ends, the vector code delivered is 7 and the in-service register does not change.
- R4: A genuine acknowledge of input 7 sets in-service bit 7. Any one acknowledge sets at most one in-service bit.
- R5: A command write to address 0 with bit 3=1 and bit 2=1 arms a poll. The next read at address 0 returns bit 7 = request pending and bits 2:0 = the winning input, with all other bits 0. That read acknowledges the winner, and it overrides the status selection.
- R6: After reset all registers are zero, and a read at address 0 returns the request register. A command write with bit 3=1 and bit 1=1 selects the in-service register for these reads when bit 0=1, and the request register when bit 0=0.
- R7: A read at address 1 returns the mask register. A write to address 1 loads it.
- R8: A masked input never raises `irq` and never wins priority resolution.
- R9: `irq` is high exactly when the winning unmasked request has a lower index than every set in-service bit. It is registered and follows its inputs by one cycle.
- R10: A command write to address 0 with bit 5=1 clears the lowest-index set in-service bit (non-specific end-of-interrupt).
- R11: When several unmasked requests are pending, the lowest-index input wins.
- R12: `vec_valid` pulses for one cycle after the second acknowledge pulse ends, with `vec_code` holding the number recorded at the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_mode | input | 1 | Trigger mode: 0 edge, 1 level |
| req_in | input | 8 | Interrupt request lines |
| ack_in | input | 1 | Acknowledge pulse, high during a pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | One-cycle strobe marking a delivered vector |
| vec_code | output | 3 | Delivered input number |

## Verification
The assertions take the following for granted about the processor side. End-of-interrupt is never written in the same cycle as an acknowledge. A poll read never coincides with the end of a first acknowledge pulse. Acknowledge pulses arrive in pairs, and each pulse stays high for at least one sampled cycle. The stimulus drives every input on the falling clock edge, issues one bus operation or one acknowledge pair at a time, and lets a few idle cycles pass between them. The request lines change only when no acknowledge is active, except in the cases that deliberately drop a request early.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int CMD_EOI_BIT  = 5;
  localparam int CMD_SEL_BIT  = 3;
  localparam int CMD_POLL_BIT = 2;
  localparam int CMD_RR_BIT   = 1;
  localparam int CMD_RIS_BIT  = 0;

  typedef enum logic {SEL_REQ = 1'b0, SEL_SVC = 1'b1} stat_sel_e;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            level_mode,
  input  logic [N_IN-1:0] req_in,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] irr_o
);
  logic [N_IN-1:0] arm_q;
  logic [N_IN-1:0] irr_q;

  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) begin
          arm_q[i] <= 1'b0;
          irr_q[i] <= 1'b0;
        end else begin
          irr_q[i] <= req_in[i] & (level_mode | arm_q[i]);
          arm_q[i] <= ~req_in[i] | (arm_q[i] & ~clr[i]);
        end
      end
    end
  endgenerate

  assign irr_o = irr_q;
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N_IN = 8,
  localparam int CODE_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]   irr,
  input  logic [N_IN-1:0]   imr,
  input  logic [N_IN-1:0]   isr,
  output logic              any_o,
  output logic [CODE_W-1:0] win_o,
  output logic [N_IN-1:0]   win_hot_o,
  output logic [N_IN-1:0]   svc_top_hot_o,
  output logic              irq_raw_o
);
  logic [N_IN-1:0] pend;
  logic [CODE_W:0] svc_idx;

  assign pend = irr & ~imr;

  always_comb begin
    win_o     = '0;
    win_hot_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_o     = CODE_W'(i);
        win_hot_o = '0;
        win_hot_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    svc_idx       = (CODE_W+1)'(N_IN);
    svc_top_hot_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (isr[i]) begin
        svc_idx       = (CODE_W+1)'(i);
        svc_top_hot_o = '0;
        svc_top_hot_o[i] = 1'b1;
      end
    end
  end

  assign any_o     = |pend;
  assign irq_raw_o = any_o && ({1'b0, win_o} < svc_idx);
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq #(
  parameter int CODE_W = 3,
  parameter int DEF_CODE = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_in,
  input  logic              any_pend,
  input  logic [CODE_W-1:0] win,
  output logic              first_o,
  output logic              take_o,
  output logic              vec_valid,
  output logic [CODE_W-1:0] vec_code
);
  logic              ack_q;
  logic              phase_q;
  logic [CODE_W-1:0] code_q;
  logic              fall;

  assign fall    = ack_q & ~ack_in;
  assign first_o = fall & ~phase_q;
  assign take_o  = first_o & any_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      phase_q   <= 1'b0;
      code_q    <= '0;
      vec_valid <= 1'b0;
      vec_code  <= '0;
    end else begin
      ack_q     <= ack_in;
      vec_valid <= fall & phase_q;
      if (first_o) code_q <= any_pend ? win : CODE_W'(DEF_CODE);
      if (fall) phase_q <= ~phase_q;
      if (fall & phase_q) vec_code <= code_q;
    end
  end

  assert_vec_single_R12: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int DATA_W = 8,
  localparam int CODE_W = $clog2(N_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              level_mode,
  input  logic [N_IN-1:0]   req_in,
  input  logic              ack_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              vec_valid,
  output logic [CODE_W-1:0] vec_code
);
  logic [N_IN-1:0]   irr, imr_q, isr_q, isr_n;
  logic [N_IN-1:0]   win_hot, svc_top_hot, set_hot;
  logic [CODE_W-1:0] win;
  logic              any_pend, irq_raw;
  logic              ack_first, ack_take, poll_take;
  logic              poll_q;
  stat_sel_e         sel_q;
  logic              cmd_w, eoi_w, poll_rd;

  assign cmd_w     = wr_en & ~addr;
  assign eoi_w     = cmd_w & wdata[CMD_EOI_BIT];
  assign poll_rd   = rd_en & ~addr & poll_q;
  assign poll_take = poll_rd & any_pend;
  assign set_hot   = (ack_take | poll_take) ? win_hot : '0;

  pic_req_latch #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst(rst), .level_mode(level_mode),
    .req_in(req_in), .clr(set_hot), .irr_o(irr)
  );

  pic_prio_resolve #(.N_IN(N_IN)) u_res (
    .irr(irr), .imr(imr_q), .isr(isr_q),
    .any_o(any_pend), .win_o(win), .win_hot_o(win_hot),
    .svc_top_hot_o(svc_top_hot), .irq_raw_o(irq_raw)
  );

  pic_ack_seq #(.CODE_W(CODE_W), .DEF_CODE(N_IN-1)) u_ack (
    .clk(clk), .rst(rst), .ack_in(ack_in),
    .any_pend(any_pend), .win(win),
    .first_o(ack_first), .take_o(ack_take),
    .vec_valid(vec_valid), .vec_code(vec_code)
  );

  always_comb begin
    isr_n = isr_q;
    if (eoi_w) isr_n = isr_n & ~svc_top_hot;
    isr_n = isr_n | set_hot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q  <= '0;
      isr_q  <= '0;
      poll_q <= 1'b0;
      sel_q  <= SEL_REQ;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      isr_q <= isr_n;
      irq   <= irq_raw;
      if (wr_en && addr) imr_q <= wdata[N_IN-1:0];
      if (cmd_w && wdata[CMD_SEL_BIT]) begin
        poll_q <= wdata[CMD_POLL_BIT];
        if (wdata[CMD_RR_BIT])
          sel_q <= wdata[CMD_RIS_BIT] ? SEL_SVC : SEL_REQ;
      end else if (poll_rd) begin
        poll_q <= 1'b0;
      end
      if (rd_en) begin
        if (addr) begin
          rdata <= DATA_W'(imr_q);
        end else if (poll_q) begin
          rdata <= '0;
          rdata[DATA_W-1]   <= any_pend;
          rdata[CODE_W-1:0] <= any_pend ? win : '0;
        end else begin
          rdata <= (sel_q == SEL_SVC) ? DATA_W'(isr_q) : DATA_W'(irr);
        end
      end
    end
  end

  assert_irq_has_req_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(irr & ~imr_q)));

  assert_isr_one_new_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  assert_eoi_drop_R10: assert property (@(posedge clk) disable iff (rst)
    $past(eoi_w && (isr_q != '0) && !ack_take && !poll_take)
      |-> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  assert_default_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    $past(ack_first && !any_pend && !eoi_w && !poll_take)
      |-> (isr_q == $past(isr_q)));

  assert_mask_excl_R8: assert property (@(posedge clk) disable iff (rst)
    any_pend |-> !imr_q[win]);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       level_mode = 1'b0;
  logic [7:0] req_in = '0;
  logic       ack_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, vec_valid;
  logic [2:0] vec_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .level_mode(level_mode), .req_in(req_in),
    .ack_in(ack_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .vec_valid(vec_valid),
    .vec_code(vec_code)
  );

  // reference model state
  bit [7:0] m_irr, m_arm, m_isr, m_imr, m_rdata;
  bit       m_poll, m_sel, m_ackq, m_phase, m_irq, m_vv;
  int       m_code, m_vc;

  function automatic int first_set(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_irr = 0; m_arm = 0; m_isr = 0; m_imr = 0; m_rdata = 0;
      m_poll = 0; m_sel = 0; m_ackq = 0; m_phase = 0; m_irq = 0;
      m_vv = 0; m_code = 0; m_vc = 0;
    end else begin
      int w, top;
      bit fall, take;
      bit [7:0] setb, nisr;
      w    = first_set(m_irr & ~m_imr);
      top  = first_set(m_isr);
      fall = m_ackq && !ack_in;
      setb = 0;
      take = 0;
      if (fall && !m_phase) begin       // first pulse end: R3 R4 R11
        m_code = (w < 8) ? w : 7;
        take = (w < 8);
      end
      if (rd_en) begin
        if (addr) m_rdata = m_imr;                         // R7
        else if (m_poll) begin                             // R5
          m_rdata = (w < 8) ? (8'h80 | 8'(w)) : 8'h00;
          if (w < 8) take = 1;
        end else m_rdata = m_sel ? m_isr : m_irr;          // R6
      end
      if (take) setb[w] = 1;
      nisr = m_isr;
      if (wr_en && !addr && wdata[5] && top < 8) nisr[top] = 0;  // R10
      nisr |= setb;
      m_irq = (w < 8) && (w < top);                        // R8 R9
      m_vv  = fall && m_phase;                             // R12
      if (fall && m_phase) m_vc = m_code;
      if (fall) m_phase = !m_phase;
      if (wr_en && addr) m_imr = wdata;
      if (wr_en && !addr && wdata[3]) begin
        m_poll = wdata[2];
        if (wdata[1]) m_sel = wdata[0];
      end else if (rd_en && !addr && m_poll) m_poll = 0;
      for (int i = 0; i < 8; i++) begin                    // R1 R2
        m_irr[i] = req_in[i] && (level_mode || m_arm[i]);
        m_arm[i] = !req_in[i] || (m_arm[i] && !setb[i]);
      end
      m_isr = nisr;
      m_ackq = ack_in;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R9 irq actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
      checks++;
      if (vec_valid !== m_vv || (m_vv && vec_code !== 3'(m_vc))) begin
        errors++;
        $display("FAIL R12 vec actual %0b/%0d expected %0b/%0d at %0t",
                 vec_valid, vec_code, m_vv, m_vc, $time);
      end
      checks++;
      if (rdata !== m_rdata) begin
        errors++;
        $display("FAIL R5/R6/R7 rdata actual %h expected %h at %0t", rdata, m_rdata, $time);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(bit a, bit [7:0] d);
    wr_en = 1; addr = a; wdata = d; @(negedge clk); wr_en = 0; idle(2);
  endtask
  task automatic rd(bit a);
    rd_en = 1; addr = a; @(negedge clk); rd_en = 0; idle(2);
  endtask
  task automatic pulse();
    ack_in = 1; idle(2); ack_in = 0; idle(2);
  endtask
  task automatic ack_pair();
    pulse(); pulse(); idle(2);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(4);
    rst = 0;
    idle(3);
    rd(0);                       // R6 reset: request register reads 0
    rd(1);                       // R7 mask reads 0
    // R1 edge request on input 3
    req_in = 8'h08; idle(3);
    ack_pair();                  // R12 code 3
    wr(0, 8'h0B);                // R6 select in-service
    rd(0);
    idle(4);                     // R1 still high, no new request
    wr(0, 8'h20);                // R10
    rd(0);
    // R11 priority between 5 and 2, then R9 nesting
    req_in = 8'h24; idle(3);
    ack_pair();
    req_in = 8'h26; idle(3);     // input 1 preempts in-service 2
    ack_pair();
    wr(0, 8'h20); wr(0, 8'h20); idle(3);
    ack_pair();                  // input 5 now
    wr(0, 8'h20);
    req_in = 8'h00; idle(3);
    // R3 default code: request drops before first pulse ends
    req_in = 8'h40; idle(3);
    ack_in = 1; idle(1); req_in = 8'h00; idle(2); ack_in = 0; idle(2);
    pulse(); idle(2);
    rd(0);
    // R4 genuine input 7
    req_in = 8'h80; idle(3);
    ack_pair();
    rd(0);
    wr(0, 8'h20);
    req_in = 8'h00; idle(2);
    // R8 masked input 4
    wr(1, 8'h10);
    rd(1);                       // R7
    req_in = 8'h10; idle(4);
    req_in = 8'h18; idle(3);
    ack_pair();
    wr(0, 8'h20);
    wr(1, 8'h00); idle(3);       // unmask: input 4 request latched
    // R5 poll read acts as acknowledge
    wr(0, 8'h0C);
    rd(0);
    rd(0);                       // poll consumed, status read again
    wr(0, 8'h20);
    wr(0, 8'h0C); req_in = 8'h00; idle(2);
    rd(0);                       // poll with nothing pending
    // R2 level mode re-raise after end-of-interrupt
    level_mode = 1; wr(0, 8'h0A);
    req_in = 8'h01; idle(3);
    ack_pair();
    rd(0);
    wr(0, 8'h20); idle(4);
    ack_pair();
    req_in = 8'h00;
    wr(0, 8'h20); idle(4);
    finish_run();
  end
endmodule